// File: doc/BRIEF.md
# Frame Skew Meter

This block measures how far an incoming frame-evaluation signal lags behind the local frame pulse. Software uses the result to choose a per-stream input delay. It samples both signals on a clock that runs at twice the serial bit clock, so one count of the result equals half a bit-clock period.

Software arms a measurement by raising a start bit. The start bit must first have stayed low for a whole frame. The bus format is a static input and selects the edge polarity. In the first format the frame pulse is active low, and falling edges are compared. In the second format the frame pulse is active high, and rising edges are compared.

After arming, the first reference frame edge opens a one-frame window and the next reference edge closes it. The lag of the first matching evaluation edge is then latched, and a completion flag is raised. The flag stays up while the start bit is held high. Dropping the start bit clears the flag and makes the block ready for another cycle.

Top module: `frame_skew_meter`

## Requirements
- R1: A rising start bit arms a measurement only if at least two reference frame edges were seen while the start bit was low. A rise after a shorter low period is ignored, and no completion follows.
- R2: After a qualified rise, the first reference edge opens the window and the next reference edge closes it. The completion flag rises in the cycle after the closing edge, between frame_len+1 and 2*frame_len+1 cycles after the rise.
- R3: With `fmt_gci_i`=0, the reference edge is a falling edge of `fp_i` and the matching edge is a falling edge of `fe_i`. A rising edge of `fe_i` is not counted.
- R4: With `fmt_gci_i`=1, the reference edge is a rising edge of `fp_i` and the matching edge is a rising edge of `fe_i`. A falling edge of `fe_i` is not counted.
- R5: The result is the number of clock cycles from the opening reference edge to the first matching edge. An edge in the same cycle as the opening edge gives 0. Later edges in the same window are ignored.
- R6: The result is saturated at the all-ones value of the OFS_W-bit field (4095 at the default of 12 bits). This applies when the lag exceeds that value and when no matching edge arrives before the closing reference edge. The completion flag is still raised in both cases.
- R7: While the start bit is low, the completion flag is 0 from the next cycle on. Lowering the start bit during a measurement abandons it with no completion. The last latched result is kept.
- R8: While the start bit stays high after completion, the flag stays 1 and the result does not change, even if the evaluation input moves. A new measurement needs the start bit to go low and then rise again.
- R9: A synchronous active-high reset clears the flag and the result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, twice the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| fmt_gci_i | input | 1 | Bus format: 0 compares falling edges, 1 compares rising edges |
| fp_i | input | 1 | Frame pulse |
| fe_i | input | 1 | Frame evaluation input |
| start_i | input | 1 | Start bit from the control register |
| skew_ofs_o | output | OFS_W | Latched skew in half bit-clock units |
| skew_done_o | output | 1 | Completion flag |

## Verification
The bench places evaluation edges in the same cycle as the opening frame edge, at mid-frame, and twice within one window. A design with an off-by-one counter would report 1 instead of 0. A design that keeps the last edge would report the later position.

Each format is also driven with an evaluation pulse of the opposite shape. This exposes a design that reacts to the wrong edge, because the result lands one cycle early. A long frame with a late edge, and a frame with no edge at all, must both give 4095 and still complete; a counter that wraps, or a window that never closes, fails these.

A brief low pulse on the start bit, and an abort in the middle of a measurement, must both produce no completion. The bench also moves the evaluation input while a result is held, and the result must not change.

// File: rtl/fsm_pkg.sv
package fsm_pkg;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARMED = 2'd1,
        MS_MEAS  = 2'd2,
        MS_DONE  = 2'd3
    } meas_state_e;

    // Reference edges the start bit must span while low to qualify
    localparam int unsigned QUAL_EDGES = 2;

    // Index of each observed input in the edge detector array
    localparam int unsigned SIG_FP  = 0;
    localparam int unsigned SIG_FE  = 1;
    localparam int unsigned SIG_NUM = 2;

    // True when a sample pair shows a transition toward the selected level
    function automatic logic edge_toward(input logic now_v, input logic prev_v,
                                         input logic want_high);
        return (now_v == want_high) && (prev_v != want_high);
    endfunction

endpackage

// File: rtl/fsm_edge_det.sv
module fsm_edge_det
    import fsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    input  logic rise_sel_i,
    output logic hit_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= sig_i;
        else     prev_q <= sig_i;
    end

    always_comb hit_o = edge_toward(sig_i, prev_q, rise_sel_i);

    // R3 and R4: a hit only ever follows a move toward the selected level
    p_edge_dir_r3: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (sig_i == rise_sel_i) && ($past(sig_i) != rise_sel_i));

endmodule

// File: rtl/fsm_arm_ctrl.sv
module fsm_arm_ctrl
    import fsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic ref_hit_i,
    output logic open_o,
    output logic close_o,
    output logic run_o,
    output logic done_o
);

    localparam int unsigned QW = $clog2(QUAL_EDGES + 1);

    logic          start_q;
    logic [QW-1:0] low_edges;
    meas_state_e   st;
    logic          start_rise;
    logic          qualified;

    always_comb begin
        start_rise = start_i && !start_q;
        qualified  = (low_edges == QW'(QUAL_EDGES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= 1'b0;
            low_edges <= '0;
            st        <= MS_IDLE;
        end else begin
            start_q <= start_i;
            if (start_i)
                low_edges <= '0;
            else if (ref_hit_i && !qualified)
                low_edges <= low_edges + 1'b1;

            case (st)
                MS_IDLE:  if (start_rise && qualified) st <= MS_ARMED;
                MS_ARMED: if (!start_i) st <= MS_IDLE;
                          else if (ref_hit_i) st <= MS_MEAS;
                MS_MEAS:  if (!start_i) st <= MS_IDLE;
                          else if (ref_hit_i) st <= MS_DONE;
                MS_DONE:  if (!start_i) st <= MS_IDLE;
                default:  st <= MS_IDLE;
            endcase
        end
    end

    always_comb begin
        open_o  = (st == MS_ARMED) && start_i && ref_hit_i;
        close_o = (st == MS_MEAS) && start_i && ref_hit_i;
        run_o   = (st == MS_MEAS) && start_i;
        done_o  = (st == MS_DONE);
    end

    // R1: an unqualified rise leaves the sequencer idle
    p_no_arm_unqual_r1: assert property (@(posedge clk) disable iff (rst)
        (st == MS_IDLE && start_rise && !qualified) |=> (st == MS_IDLE));

    // R2: an armed sequencer opens the window on a reference edge
    p_open_window_r2: assert property (@(posedge clk) disable iff (rst)
        (st == MS_ARMED && start_i && ref_hit_i) |=> (st == MS_MEAS));

    // R7: a low start bit clears completion by the next cycle
    p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    // R8: completion holds while the start bit stays high
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> done_o);

endmodule

// File: rtl/fsm_skew_cnt.sv
module fsm_skew_cnt
    import fsm_pkg::*;
#(
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             run_i,
    input  logic             close_i,
    input  logic             ev_hit_i,
    output logic [OFS_W-1:0] ofs_o
);

    localparam logic [OFS_W-1:0] CNT_MAX = '1;
    localparam logic [OFS_W-1:0] CNT_ONE = OFS_W'(1);

    logic [OFS_W-1:0] cnt_q;
    logic [OFS_W-1:0] cap_q;
    logic             got_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cap_q <= '0;
            got_q <= 1'b0;
            ofs_o <= '0;
        end else if (open_i) begin
            cnt_q <= CNT_ONE;
            cap_q <= '0;
            got_q <= ev_hit_i;
        end else if (close_i) begin
            ofs_o <= got_q ? cap_q : CNT_MAX;
        end else if (run_i) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
            if (ev_hit_i && !got_q) begin
                cap_q <= cnt_q;
                got_q <= 1'b1;
            end
        end
    end

    // R6: the running count never wraps past its maximum
    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (run_i && !open_i && !close_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R5: once an edge is captured, later edges leave the capture alone
    p_first_only_r5: assert property (@(posedge clk) disable iff (rst)
        (run_i && !open_i && !close_i && got_q) |=> (got_q && $stable(cap_q)));

    // R8: the published result only moves at a window close
    p_ofs_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !close_i |=> $stable(ofs_o));

endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter
    import fsm_pkg::*;
#(
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_gci_i,
    input  logic             fp_i,
    input  logic             fe_i,
    input  logic             start_i,
    output logic [OFS_W-1:0] skew_ofs_o,
    output logic             skew_done_o
);

    logic [SIG_NUM-1:0] raw_sig;
    logic [SIG_NUM-1:0] sig_hit;
    logic               win_open;
    logic               win_close;
    logic               win_run;

    always_comb begin
        raw_sig         = '0;
        raw_sig[SIG_FP] = fp_i;
        raw_sig[SIG_FE] = fe_i;
    end

    // Both inputs share one polarity choice driven by the bus format
    for (genvar g = 0; g < SIG_NUM; g++) begin : g_edge
        fsm_edge_det u_det (
            .clk        (clk),
            .rst        (rst),
            .sig_i      (raw_sig[g]),
            .rise_sel_i (fmt_gci_i),
            .hit_o      (sig_hit[g])
        );
    end

    fsm_arm_ctrl u_arm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .ref_hit_i (sig_hit[SIG_FP]),
        .open_o    (win_open),
        .close_o   (win_close),
        .run_o     (win_run),
        .done_o    (skew_done_o)
    );

    fsm_skew_cnt #(.OFS_W(OFS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .open_i   (win_open),
        .run_i    (win_run),
        .close_i  (win_close),
        .ev_hit_i (sig_hit[SIG_FE]),
        .ofs_o    (skew_ofs_o)
    );

    // R2: completion is only entered straight after a window close
    p_done_after_close_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(skew_done_o) |-> $past(win_close));

endmodule

// File: tb/frame_skew_meter_bench.sv
module frame_skew_meter_bench;

    localparam int OFS_W = 12;
    localparam int SAT   = (1 << OFS_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fmt_gci_i = 1'b0;
    logic             fp_i = 1'b1;
    logic             fe_i = 1'b1;
    logic             start_i = 1'b0;
    logic [OFS_W-1:0] skew_ofs_o;
    logic             skew_done_o;

    frame_skew_meter #(.OFS_W(OFS_W)) u_frame_skew_meter (
        .clk         (clk),
        .rst         (rst),
        .fmt_gci_i   (fmt_gci_i),
        .fp_i        (fp_i),
        .fe_i        (fe_i),
        .start_i     (start_i),
        .skew_ofs_o  (skew_ofs_o),
        .skew_done_o (skew_done_o)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Frame generator settings
    int f_len  = 40;
    int f_off  = 5;
    int f_off2 = -1;
    bit f_en   = 1'b1;
    bit f_inv  = 1'b0;
    int phase  = 0;

    int    exp_q[$];
    string tag_q[$];
    bit    done_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Frame and evaluation waveform generator
    always @(negedge clk) begin
        logic act_fp;
        logic act_fe;
        logic fe_high;
        phase   = (phase >= f_len - 1) ? 0 : phase + 1;
        act_fp  = (phase == 0);
        fp_i    <= fmt_gci_i ? act_fp : ~act_fp;
        act_fe  = f_en && (phase == f_off || phase == f_off2);
        fe_high = fmt_gci_i ^ f_inv;
        fe_i    <= fe_high ? act_fe : ~act_fe;
    end

    // Monitor: every completion rise consumes one expected result
    always @(negedge clk) begin
        if (!rst && skew_done_o && !done_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1/R7 unexpected completion", 1, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'(skew_ofs_o) == e, t, int'(skew_ofs_o), e);
            end
        end
        done_prev = skew_done_o;
    end

    // Driver: sets up frames, qualifies, raises start, waits for completion
    task automatic run_meas(input int len, input int off, input int off2,
                            input bit en, input bit inv, input bit g,
                            input int exp, input string tag);
        int lat;
        start_i = 1'b0;
        f_len = len; f_off = off; f_off2 = off2; f_en = en; f_inv = inv;
        fmt_gci_i = g;
        repeat (3 * len + 2) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        start_i = 1'b1;
        lat = 0;
        while (!skew_done_o && lat < 2 * len + 10) begin
            @(negedge clk);
            lat++;
        end
        // R2 completion latency window
        chk(lat >= len + 1 && lat <= 2 * len + 1, "R2 latency", lat, 2 * len + 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(skew_done_o == 1'b0, "R9 done after reset", int'(skew_done_o), 0);
        chk(int'(skew_ofs_o) == 0, "R9 result after reset", int'(skew_ofs_o), 0);
        rst = 1'b0;

        // R3: falling-edge format, mid-frame lag
        run_meas(40, 5, -1, 1'b1, 1'b0, 1'b0, 5, "R3 R5 falling lag 5");

        // R8: hold with start high while the evaluation edge moves
        f_off = 9;
        repeat (130) @(negedge clk);
        chk(skew_done_o == 1'b1, "R8 flag held", int'(skew_done_o), 1);
        chk(int'(skew_ofs_o) == 5, "R8 result held", int'(skew_ofs_o), 5);

        // R7: lowering start clears the flag next cycle, result kept
        start_i = 1'b0;
        @(negedge clk);
        chk(skew_done_o == 1'b0, "R7 flag cleared", int'(skew_done_o), 0);
        chk(int'(skew_ofs_o) == 5, "R7 result kept", int'(skew_ofs_o), 5);

        // R4: rising-edge format
        run_meas(40, 7, -1, 1'b1, 1'b0, 1'b1, 7, "R4 rising lag 7");
        // R5: coincident edges give zero in both formats
        run_meas(40, 0, -1, 1'b1, 1'b0, 1'b0, 0, "R5 zero lag falling");
        run_meas(40, 0, -1, 1'b1, 1'b0, 1'b1, 0, "R5 zero lag rising");
        // R3/R4: opposite-shape pulse is caught only on its trailing edge
        run_meas(40, 6, -1, 1'b1, 1'b1, 1'b0, 7, "R3 wrong polarity ignored");
        run_meas(40, 6, -1, 1'b1, 1'b1, 1'b1, 7, "R4 wrong polarity ignored");
        // R5: only the first edge in a window counts
        run_meas(40, 4, 11, 1'b1, 1'b0, 1'b0, 4, "R5 first edge only");
        // R6: lag beyond the field saturates
        run_meas(4200, 4150, -1, 1'b1, 1'b0, 1'b0, SAT, "R6 late edge saturates");
        run_meas(40, 5, -1, 1'b1, 1'b0, 1'b1, 5, "R4 after long frames");
        // R6: no edge in the window saturates and still completes
        run_meas(40, 5, -1, 1'b0, 1'b0, 1'b0, SAT, "R6 missing edge");

        // R1: short low pulse on start does not arm
        f_en = 1'b1; f_off = 3;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        repeat (130) @(negedge clk);
        chk(skew_done_o == 1'b0, "R1 short low no arm", int'(skew_done_o), 1'b0);
        chk(int'(skew_ofs_o) == SAT, "R1 result untouched", int'(skew_ofs_o), SAT);

        // R7: abort in the middle of a measurement
        start_i = 1'b0;
        repeat (122) @(negedge clk);
        start_i = 1'b1;
        repeat (45) @(negedge clk);
        start_i = 1'b0;
        repeat (130) @(negedge clk);
        chk(skew_done_o == 1'b0, "R7 abort no completion", int'(skew_done_o), 0);
        chk(int'(skew_ofs_o) == SAT, "R7 abort result kept", int'(skew_ofs_o), SAT);

        chk(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R2 watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule